// File: doc/BRIEF.md
# Multi-Context Instruction Dispatch Scheduler

This block feeds a bank of typed execution units from many independent program contexts. Each context owns a private instruction store, a program counter and a return-address stack. Every cycle the block looks at the instruction each live context would issue next. It picks one of those contexts in rotating order and acts on its instruction.

Subroutine calls and returns are resolved inside the block and never leave it. Any other defined opcode is placed in the queue of the one worker unit that implements that opcode, so each worker only ever sees a single kind of instruction. If a worker's queue is full, only the contexts waiting on that worker are held back. The rest keep issuing.

Software loads a context's program through a simple write port and then launches the context with a start pulse. Workers drain their queues through a valid/ready handshake.

Top module: `mt_dispatch`

## Requirements
- R1: After a synchronous reset every context is halted (`ctx_run` all zero) and no worker lane is valid.
- R2: A start pulse for context c sets its program counter to 0, empties its return stack and marks it running (`ctx_run[c]` high on the following cycle).
- R3: An instruction word is 32 bits, with the opcode in [31:27], the destination index in [26:24], the source index in [23:21] and the immediate in [15:0]. An opcode below NWORK goes to worker lane equal to the opcode. Its entry is {context id, opcode, dst, src, imm}, MSB first, `ENT_W` bits wide, and lane w occupies `wk_data[w*ENT_W +: ENT_W]`.
- R4: At most one instruction is issued per cycle. Contexts are chosen in rotating order: after context c issues, the search starts at c+1, wrapping at NCTX.
- R5: A context that is halted, or whose next instruction targets a full worker queue (QDEPTH entries before this cycle's pop), is skipped for the cycle. Its program counter advances only when its instruction is issued, and other contexts keep issuing.
- R6: CALL (opcode 30) pushes PC+1 onto the context's return stack and jumps to imm modulo PROG_DEPTH. Nothing is queued to a worker.
- R7: RET (opcode 31) pops the return stack into the program counter. A RET on an empty stack halts the context.
- R8: A CALL issued while the return stack already holds RS_DEPTH (8) entries halts the context.
- R9: Opcodes 28 and 29 (at or above NWORK, below 30) are discarded. Nothing is queued and the program counter advances.
- R10: Each worker queue is first-in first-out, QDEPTH deep. A valid lane keeps its data unchanged until `wk_ready` accepts it.
- R11: The program counter wraps from PROG_DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | NCTX | Per-context launch pulse |
| prog_we | input | 1 | Program store write enable |
| prog_ctx | input | CTX_W | Context whose store is written |
| prog_addr | input | PC_W | Word address within that store |
| prog_data | input | 32 | Instruction word to write |
| wk_ready | input | NWORK | Worker accepts its lane's head entry |
| ctx_run | output | NCTX | Context is running |
| wk_valid | output | NWORK | Worker lane holds an entry |
| wk_data | output | NWORK*ENT_W | Head entry of each worker lane |

## Verification
On every cycle, the in-RTL properties check several behaviours. Only running contexts are granted. No queue is pushed while full. A stalled lane holds its data. A CALL with room jumps and deepens the stack, while a RET on an empty stack or a CALL on a full one halts the context. Rotation order, stalls that fall on one context while others keep going, program-counter wrap, discarded opcodes and the order of nested calls and returns can only be seen across many cycles. The bench's scenarios show these against a behavioural model driven with randomized worker backpressure.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int INSN_W = 32;
  localparam int OP_W   = 5;
  localparam int REG_W  = 3;
  localparam int IMM_W  = 16;

  localparam logic [OP_W-1:0] OP_CALL = 5'd30;
  localparam logic [OP_W-1:0] OP_RET  = 5'd31;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src;
    logic [IMM_W-1:0] imm;
  } insn_t;
endpackage

// File: rtl/disp_ctx.sv
module disp_ctx
  import disp_pkg::*;
#(
  parameter int PROG_DEPTH = 16,
  parameter int RS_DEPTH   = 8,
  localparam int PC_W = $clog2(PROG_DEPTH),
  localparam int SP_W = $clog2(RS_DEPTH + 1),
  localparam int IX_W = $clog2(RS_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              fire,
  input  logic              we,
  input  logic [PC_W-1:0]   waddr,
  input  logic [INSN_W-1:0] wdata,
  output logic              running,
  output insn_t             insn
);
  logic [INSN_W-1:0] mem [PROG_DEPTH];
  logic [PC_W-1:0]   rstack [RS_DEPTH];
  logic [PC_W-1:0]   pc, pc_inc;
  logic [SP_W-1:0]   sp, sp_dec;
  logic [INSN_W-1:0] word;
  logic stk_full, stk_empty, do_call, do_ret, unused_pad;

  // program store: one write port, one read port at the PC
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign word       = mem[pc];
  assign insn.op    = word[31:27];
  assign insn.dst   = word[26:24];
  assign insn.src   = word[23:21];
  assign insn.imm   = word[15:0];
  assign unused_pad = ^word[20:16];

  assign pc_inc    = pc + 1'b1;
  assign sp_dec    = sp - 1'b1;
  assign stk_full  = (sp == SP_W'(RS_DEPTH));
  assign stk_empty = (sp == '0);
  assign do_call   = fire && !start && (insn.op == OP_CALL);
  assign do_ret    = fire && !start && (insn.op == OP_RET);

  always_ff @(posedge clk) begin
    if (!rst && do_call && !stk_full) rstack[sp[IX_W-1:0]] <= pc_inc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      pc      <= '0;
      sp      <= '0;
    end else if (start) begin
      running <= 1'b1;
      pc      <= '0;
      sp      <= '0;
    end else if (do_call) begin
      if (stk_full) running <= 1'b0;
      else begin
        pc <= insn.imm[PC_W-1:0];
        sp <= sp + 1'b1;
      end
    end else if (do_ret) begin
      if (stk_empty) running <= 1'b0;
      else begin
        pc <= rstack[sp_dec[IX_W-1:0]];
        sp <= sp_dec;
      end
    end else if (fire) begin
      pc <= pc_inc;
    end
  end

  p_fire_running_r5: assert property (@(posedge clk) disable iff (rst)
    fire |-> running);
  p_call_jump_r6: assert property (@(posedge clk) disable iff (rst)
    (do_call && !stk_full) |=> (pc == $past(insn.imm[PC_W-1:0])) && (sp == $past(sp) + SP_W'(1)));
  p_ret_empty_halt_r7: assert property (@(posedge clk) disable iff (rst)
    (do_ret && stk_empty) |=> !running);
  p_call_full_halt_r8: assert property (@(posedge clk) disable iff (rst)
    (do_call && stk_full) |=> !running);
endmodule

// File: rtl/disp_fifo.sv
module disp_fifo #(
  parameter int WIDTH = 29,
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  output logic             full,
  output logic             valid,
  output logic [WIDTH-1:0] dout,
  input  logic             ready
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic pop;

  assign pop   = valid && ready;
  assign full  = (cnt == CW'(DEPTH));
  assign valid = (cnt != '0);
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> valid && $stable(dout));
endmodule

// File: rtl/disp_rr.sv
module disp_rr #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] ptr;

  always_comb begin
    gnt = '0;
    any = 1'b0;
    idx = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (int'(ptr) + k) % N;
      if (!any && req[j]) begin
        any    = 1'b1;
        idx    = IW'(j);
        gnt[j] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      ptr <= '0;
    else if (any) ptr <= (idx == IW'(N - 1)) ? '0 : idx + 1'b1;
  end

  p_grant_requested_r4: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~req) == '0);
endmodule

// File: rtl/mt_dispatch.sv
module mt_dispatch
  import disp_pkg::*;
#(
  parameter int NCTX       = 4,
  parameter int PROG_DEPTH = 16,
  parameter int RS_DEPTH   = 8,
  parameter int NWORK      = 28,
  parameter int QDEPTH     = 4,
  localparam int CTX_W = $clog2(NCTX),
  localparam int PC_W  = $clog2(PROG_DEPTH),
  localparam int ENT_W = CTX_W + $bits(insn_t)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NCTX-1:0]        start,
  input  logic                   prog_we,
  input  logic [CTX_W-1:0]       prog_ctx,
  input  logic [PC_W-1:0]        prog_addr,
  input  logic [INSN_W-1:0]      prog_data,
  input  logic [NWORK-1:0]       wk_ready,
  output logic [NCTX-1:0]        ctx_run,
  output logic [NWORK-1:0]       wk_valid,
  output logic [NWORK*ENT_W-1:0] wk_data
);
  insn_t            insn [NCTX];
  logic [NCTX-1:0]  run_w, req, gnt;
  logic             any;
  logic [CTX_W-1:0] gidx;
  insn_t            sel;
  logic [ENT_W-1:0] entry;
  logic [NWORK-1:0] q_full, push;

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    logic is_work;
    disp_ctx #(.PROG_DEPTH(PROG_DEPTH), .RS_DEPTH(RS_DEPTH)) u_ctx (
      .clk(clk), .rst(rst), .start(start[c]), .fire(gnt[c]),
      .we(prog_we && (prog_ctx == CTX_W'(c))), .waddr(prog_addr), .wdata(prog_data),
      .running(run_w[c]), .insn(insn[c])
    );
    assign is_work = (int'(insn[c].op) < NWORK);
    assign req[c]  = run_w[c] && (!is_work || !q_full[insn[c].op]);
  end

  disp_rr #(.N(NCTX)) u_rr (
    .clk(clk), .rst(rst), .req(req), .gnt(gnt), .any(any), .idx(gidx)
  );

  assign sel   = insn[gidx];
  assign entry = {gidx, sel};

  for (genvar w = 0; w < NWORK; w++) begin : g_q
    assign push[w] = any && (int'(sel.op) == w);
    disp_fifo #(.WIDTH(ENT_W), .DEPTH(QDEPTH)) u_q (
      .clk(clk), .rst(rst), .push(push[w]), .din(entry), .full(q_full[w]),
      .valid(wk_valid[w]), .dout(wk_data[w*ENT_W +: ENT_W]), .ready(wk_ready[w])
    );
  end

  assign ctx_run = run_w;

  p_grant_running_r5: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~run_w) == '0);
  p_single_push_r4: assert property (@(posedge clk) disable iff (rst)
    $countones(push) <= 1);
endmodule

// File: tb/tb_mt_dispatch.sv
module tb_mt_dispatch;
  localparam int NCTX = 4, PD = 16, RSD = 8, NW = 28, QD = 4;
  localparam int CW = 2, PW = 4, EW = 29;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst;
  logic [NCTX-1:0] start;
  logic            prog_we;
  logic [CW-1:0]   prog_ctx;
  logic [PW-1:0]   prog_addr;
  logic [31:0]     prog_data;
  logic [NW-1:0]   wk_ready;
  logic [NCTX-1:0] ctx_run;
  logic [NW-1:0]   wk_valid;
  logic [NW*EW-1:0] wk_data;

  mt_dispatch dut (
    .clk(clk), .rst(rst), .start(start), .prog_we(prog_we), .prog_ctx(prog_ctx),
    .prog_addr(prog_addr), .prog_data(prog_data), .wk_ready(wk_ready),
    .ctx_run(ctx_run), .wk_valid(wk_valid), .wk_data(wk_data)
  );

  // behavioural reference
  logic [31:0]   m_prog [NCTX][PD];
  int            m_pc [NCTX];
  int            m_sp [NCTX];
  int            m_stk [NCTX][RSD];
  bit            m_run [NCTX];
  int            m_rr;
  logic [EW-1:0] m_q [NW][$];

  int checks, errors;
  bit done;
  string tag;
  logic [31:0] lfsr;
  int seen[$];

  function automatic logic [31:0] ins(int op, int d, int s, int imm);
    return {5'(op), 3'(d), 3'(s), 5'b0, 16'(imm)};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [1023:0] a, input logic [1023:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, a, e);
    end
  endtask

  function automatic bit eligible(int c);
    int op;
    op = int'(m_prog[c][m_pc[c]][31:27]);
    return (op >= NW) || (m_q[op].size() < QD);
  endfunction

  task automatic model_step();
    int g, op;
    logic [31:0] w32;
    if (rst) begin
      for (int c = 0; c < NCTX; c++) begin
        m_run[c] = 0; m_pc[c] = 0; m_sp[c] = 0;
      end
      m_rr = 0;
      for (int w = 0; w < NW; w++) m_q[w].delete();
    end else begin
      g = -1;
      for (int k = 0; k < NCTX; k++) begin
        int c;
        c = (m_rr + k) % NCTX;
        if (g < 0 && m_run[c] && eligible(c)) g = c;
      end
      for (int w = 0; w < NW; w++)
        if (m_q[w].size() > 0 && wk_ready[w]) void'(m_q[w].pop_front());
      if (g >= 0) begin
        w32 = m_prog[g][m_pc[g]];
        op = int'(w32[31:27]);
        m_rr = (g + 1) % NCTX;
        if (op < NW) m_q[op].push_back({CW'(g), w32[31:21], w32[15:0]});
        if (!start[g]) begin
          if (op == 30) begin
            if (m_sp[g] == RSD) m_run[g] = 0;
            else begin
              m_stk[g][m_sp[g]] = (m_pc[g] + 1) % PD;
              m_sp[g]++;
              m_pc[g] = int'(w32[15:0]) % PD;
            end
          end else if (op == 31) begin
            if (m_sp[g] == 0) m_run[g] = 0;
            else begin
              m_sp[g]--;
              m_pc[g] = m_stk[g][m_sp[g]];
            end
          end else m_pc[g] = (m_pc[g] + 1) % PD;
        end
      end
      for (int c = 0; c < NCTX; c++)
        if (start[c]) begin
          m_run[c] = 1; m_pc[c] = 0; m_sp[c] = 0;
        end
    end
    if (prog_we) m_prog[prog_ctx][prog_addr] = prog_data;
  endtask

  task automatic compare();
    logic [NCTX-1:0]  er;
    logic [NW-1:0]    ev;
    logic [NW*EW-1:0] ed, ad;
    for (int c = 0; c < NCTX; c++) er[c] = m_run[c];
    for (int w = 0; w < NW; w++) begin
      ev[w] = (m_q[w].size() > 0);
      ed[w*EW +: EW] = ev[w] ? m_q[w][0] : '0;
      ad[w*EW +: EW] = wk_valid[w] ? wk_data[w*EW +: EW] : '0;
    end
    chk(ctx_run === er, {tag, " run state"}, 1024'(ctx_run), 1024'(er));
    chk(wk_valid === ev, {tag, " lane valid"}, 1024'(wk_valid), 1024'(ev));
    chk(ad === ed, {tag, " lane data"}, 1024'(ad), 1024'(ed));
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic wr(int c, int a, logic [31:0] d);
    prog_we = 1'b1; prog_ctx = CW'(c); prog_addr = PW'(a); prog_data = d;
    step();
    prog_we = 1'b0;
  endtask

  task automatic go(logic [NCTX-1:0] m);
    start = m;
    step();
    start = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step();
    rst = 1'b0;
  endtask

  function automatic int imm_of(int w);
    return int'(wk_data[w*EW +: 16]);
  endfunction

  initial begin
    checks = 0; errors = 0; done = 0; tag = "R1";
    rst = 1'b1; start = '0; prog_we = 1'b0; prog_ctx = '0; prog_addr = '0;
    prog_data = '0; wk_ready = '0; lfsr = 32'h1;
    step();
    do_reset();
    chk(ctx_run == '0 && wk_valid == '0, "R1 idle after reset",
        1024'({ctx_run, wk_valid}), 1024'(0));

    // R2 R3 R4 R11: all contexts, random backpressure, long enough to wrap
    tag = "R2,R3,R4,R11";
    for (int c = 0; c < NCTX; c++)
      for (int a = 0; a < PD; a++) wr(c, a, ins((c * 7 + a) % NW, a % 8, c, c * 256 + a));
    wk_ready = '1;
    go(4'hF);
    chk(ctx_run == 4'hF, "R2 all started", 1024'(ctx_run), 1024'(4'hF));
    step();
    chk(wk_valid == NW'(1), "R4 context 0 issues first", 1024'(wk_valid), 1024'(NW'(1)));
    step();
    chk(wk_valid == (NW'(1) << 7), "R4 context 1 issues next", 1024'(wk_valid), 1024'(NW'(1) << 7));
    for (int i = 0; i < 100; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      wk_ready = NW'(lfsr ^ (lfsr >> 5));
      step();
    end
    wk_ready = '1;
    repeat (10) step();

    // R5 R10: full queues stall only their own context
    tag = "R5,R10";
    do_reset();
    for (int a = 0; a < PD; a++) begin
      wr(0, a, ins(3, 1, 2, a));
      wr(1, a, ins(5, 2, 1, a));
    end
    wk_ready = '0;
    go(4'b0011);
    repeat (12) step();
    chk(wk_valid[3] && imm_of(3) == 0, "R10 head held while not ready",
        1024'(imm_of(3)), 1024'(0));
    chk(ctx_run[1:0] == 2'b11, "R5 stalled contexts stay running", 1024'(ctx_run), 1024'(3));
    wk_ready[3] = 1'b1;
    repeat (6) step();
    chk(wk_valid[5] && imm_of(5) == 0, "R5 other lane unaffected", 1024'(imm_of(5)), 1024'(0));
    wk_ready = '1;
    repeat (8) step();

    // R6 R7: nested call and return, then return on empty stack
    tag = "R6,R7";
    do_reset();
    for (int a = 0; a < PD; a++) wr(1, a, ins(0, 0, 0, 0));
    wr(1, 0, ins(1, 0, 0, 100));
    wr(1, 1, ins(30, 0, 0, 8));
    wr(1, 2, ins(2, 0, 0, 102));
    wr(1, 3, ins(31, 0, 0, 0));
    wr(1, 8, ins(4, 0, 0, 108));
    wr(1, 9, ins(30, 0, 0, 12));
    wr(1, 10, ins(31, 0, 0, 0));
    wr(1, 12, ins(6, 0, 0, 112));
    wr(1, 13, ins(31, 0, 0, 0));
    wk_ready = '1;
    go(4'b0010);
    seen.delete();
    repeat (15) begin
      step();
      for (int w = 0; w < NW; w++) if (wk_valid[w]) seen.push_back(imm_of(w));
    end
    chk(seen.size() == 4 && seen[0] == 100 && seen[1] == 108 && seen[2] == 112 && seen[3] == 102,
        "R6 call/return issue order", 1024'(seen.size()), 1024'(4));
    chk(ctx_run[1] == 1'b0, "R7 return on empty stack halts", 1024'(ctx_run), 1024'(0));

    // R8: recursion overflows the return stack
    tag = "R8";
    do_reset();
    wr(2, 0, ins(30, 0, 0, 0));
    go(4'b0100);
    repeat (8) step();
    chk(ctx_run[2] == 1'b1 && wk_valid == '0, "R8 eight calls still running",
        1024'({ctx_run, wk_valid}), 1024'({4'b0100, NW'(0)}));
    step();
    chk(ctx_run[2] == 1'b0, "R8 ninth call halts", 1024'(ctx_run), 1024'(0));

    // R9: undefined opcodes are dropped
    tag = "R9";
    do_reset();
    wr(3, 0, ins(28, 0, 0, 1));
    wr(3, 1, ins(29, 0, 0, 2));
    wr(3, 2, ins(7, 0, 0, 3));
    wr(3, 3, ins(31, 0, 0, 0));
    wk_ready = '0;
    go(4'b1000);
    step();
    step();
    chk(wk_valid == '0 && ctx_run[3], "R9 opcodes 28 and 29 queue nothing",
        1024'(wk_valid), 1024'(0));
    step();
    chk(wk_valid[7] && imm_of(7) == 3, "R9 following instruction issued",
        1024'(imm_of(7)), 1024'(3));
    step();
    chk(ctx_run[3] == 1'b0, "R7 final return halts", 1024'(ctx_run), 1024'(0));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule